// File: doc/BRIEF.md
# Comparator Sampling Filter and Mode Controller

This block is the digital control logic for one analog comparator channel. It takes the raw comparator bit and can clean it with a majority-free agreement filter. The filter samples the bit at a rate built from one of two clock enables. A low-speed tick stands in for the slow oscillator and a high-speed tick for the fast one. When filtering is off, or while the stop indication is high, the raw bit instead passes through a plain two-flop synchronizer. The result is the filtered comparator level.

A sequencer watches each decision that the filter or synchronizer makes and tests it for the selected interrupt edge. The mode input picks one of three behaviours. In conditional one-shot mode the block stops at the first matching decision. In unconditional one-shot mode it stops after the first completed comparison. In supervision mode it keeps interrupting on every matching edge while enable stays high. In both one-shot modes the block requests that the enable bit be cleared. Software owns the enable register bit and drops it in response to that request.

Top module: `acmp_ctrl`

## Requirements
- R1: After reset, `level_o`, `irq_o` and `en_clr_o` are all 0.
- R2: With `mode_i` = 01, the first decision after `en_i` rises always produces `irq_o` and `en_clr_o`, whatever the edge selection or level.
- R3: With `mode_i` = 00, decisions that do not meet the edge condition are passed over silently. The first decision that meets it produces `irq_o` and `en_clr_o`.
- R4: With `mode_i` = 10 or 11, every decision that meets the edge condition produces `irq_o` while `en_i` is high, and `en_clr_o` is never raised.
- R5: The edge condition is decoded from `edge_sel_i`: 00 is a 0-to-1 change of the filtered level, 01 is a 1-to-0 change, 10 is either change, and 11 is never met.
- R6: When unfiltered, the level is taken through a two-flop synchronizer on the selected tick. The first decision falls on the second selected tick after `en_i` rises, and `irq_o` is visible after that clock edge.
- R7: When filtered, the level changes only after three consecutive sample points see the same raw value. A pulse shorter than three sample points is ignored. The first decision falls on the third sample point after enable.
- R8: `clk_sel_i` = 0 uses `ls_tick_i`: `smp_sel_i[0]` = 0 means unfiltered, and 1 means a sample every 2 ticks. `clk_sel_i` = 1 uses `hs_tick_i`: `smp_sel_i[1]` = 0 means unfiltered, 10 means a sample every 64 ticks, and 11 means a sample every 128 ticks.
- R9: While `stop_i` is high, the unfiltered path is used regardless of `smp_sel_i`.
- R10: With `en_i` low, no interrupt is produced, the level holds, and the sample and agreement counters restart. A later enable takes the full comparison time again.
- R11: `irq_o` in the one-shot modes lasts one cycle, and `en_clr_o` is high only in a cycle where `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_tick_i | input | 1 | High-speed clock enable |
| ls_tick_i | input | 1 | Low-speed clock enable |
| cmp_raw_i | input | 1 | Raw comparator output |
| en_i | input | 1 | Comparison enable |
| mode_i | input | 2 | Operating mode |
| clk_sel_i | input | 1 | Control clock select (0 low, 1 high speed) |
| smp_sel_i | input | 2 | Sampling interval select |
| edge_sel_i | input | 2 | Interrupt edge select |
| stop_i | input | 1 | Stop-mode indication, forces unfiltered path |
| level_o | output | 1 | Filtered comparator level |
| irq_o | output | 1 | Interrupt pulse |
| en_clr_o | output | 1 | Request to clear enable |

## Verification
The one-shot modes are tried with a level that rises, with a level that stays put, and with a level that rises and then falls under a falling-edge selection. These cases separate the unconditional completion from the conditional one. The cycle count to the first interrupt is measured for every clock-select and sampling combination, including stop forcing. This tells apart the 2-tick synchronizer, the 2-, 64- and 128-tick sample periods, and which tick drives each of them. A sub-threshold pulse shows glitch rejection. Edge selections switched during supervision show each decode. An abort in the middle of a comparison, followed by re-enable, shows that the counters restart.

// File: rtl/acmp_pkg.sv
package acmp_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic nxt);
    logic h;
    case (edge_sel_e'(sel))
      EDGE_RISE: h = !cur && nxt;
      EDGE_FALL: h = cur && !nxt;
      EDGE_BOTH: h = cur != nxt;
      default:   h = 1'b0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/acmp_tick_gen.sv
module acmp_tick_gen #(
  parameter int LS_DIV    = 2,
  parameter int HS_DIV_LO = 64,
  parameter int HS_DIV_HI = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       hs_tick_i,
  input  logic       ls_tick_i,
  input  logic       clk_sel_i,
  input  logic [1:0] smp_sel_i,
  input  logic       stop_i,
  output logic       base_tick_o,
  output logic       filt_on_o,
  output logic       smp_tick_o
);
  localparam int HS_MAX  = (HS_DIV_HI > HS_DIV_LO) ? HS_DIV_HI : HS_DIV_LO;
  localparam int MAX_DIV = (LS_DIV > HS_MAX) ? LS_DIV : HS_MAX;
  localparam int DIV_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [DIV_W-1:0] LS_LIM = DIV_W'(LS_DIV - 1);
  localparam logic [DIV_W-1:0] LO_LIM = DIV_W'(HS_DIV_LO - 1);
  localparam logic [DIV_W-1:0] HI_LIM = DIV_W'(HS_DIV_HI - 1);

  logic [DIV_W-1:0] div_q, lim;

  assign base_tick_o = clk_sel_i ? hs_tick_i : ls_tick_i;
  assign filt_on_o   = !stop_i && (clk_sel_i ? smp_sel_i[1] : smp_sel_i[0]);

  always_comb begin
    if (!clk_sel_i)        lim = LS_LIM;
    else if (smp_sel_i[0]) lim = HI_LIM;
    else                   lim = LO_LIM;
  end

  assign smp_tick_o = en_i && filt_on_o && base_tick_o && (div_q == lim);

  // divider restarts with each enable so comparison time is fixed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    div_q <= '0;
    else if (!en_i || !filt_on_o)   div_q <= '0;
    else if (base_tick_o)           div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/acmp_filter.sv
module acmp_filter #(
  parameter int FILT_CNT = 3,
  parameter int SYNC_CNT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  input  logic base_tick_i,
  input  logic smp_tick_i,
  input  logic filt_on_i,
  output logic level_o,
  output logic dec_o,
  output logic nxt_lvl_o
);
  localparam int CNT_MAX = (FILT_CNT > SYNC_CNT) ? FILT_CNT : SYNC_CNT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             s1_q, cand_q, lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    dec_o     = 1'b0;
    nxt_lvl_o = lvl_q;
    if (en_i) begin
      if (filt_on_i) begin
        if (smp_tick_i && cnt_q == CNT_W'(FILT_CNT - 1) && s1_q == cand_q) begin
          dec_o     = 1'b1;
          nxt_lvl_o = cand_q;
        end
      end else if (base_tick_i && cnt_q >= CNT_W'(SYNC_CNT - 1)) begin
        dec_o     = 1'b1;
        nxt_lvl_o = s1_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      cand_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (base_tick_i) s1_q <= raw_i;
      if (dec_o)       lvl_q <= nxt_lvl_o;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (filt_on_i) begin
        if (smp_tick_i) begin
          if (cnt_q == '0 || s1_q != cand_q) begin
            cand_q <= s1_q;
            cnt_q  <= CNT_W'(1);
          end else if (cnt_q < CNT_W'(FILT_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (base_tick_i && cnt_q < CNT_W'(SYNC_CNT)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/acmp_seq.sv
module acmp_seq
  import acmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] edge_sel_i,
  input  logic       dec_i,
  input  logic       lvl_i,
  input  logic       nxt_lvl_i,
  output logic       irq_o,
  output logic       en_clr_o
);
  logic fin_q, irq_q, clr_q, irq_d, clr_d, hit;

  assign hit = edge_hit(edge_sel_i, lvl_i, nxt_lvl_i);

  always_comb begin
    irq_d = 1'b0;
    clr_d = 1'b0;
    if (en_i && dec_i) begin
      if (mode_i[1]) begin
        irq_d = hit;
      end else if (!fin_q && (mode_i[0] || hit)) begin
        irq_d = 1'b1;
        clr_d = 1'b1;
      end
    end
  end

  // fin_q blocks repeat one-shots until software drops enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q <= 1'b0;
      irq_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      fin_q <= en_i && (fin_q || clr_d);
      irq_q <= irq_d;
      clr_q <= clr_d;
    end
  end

  assign irq_o    = irq_q;
  assign en_clr_o = clr_q;
endmodule

// File: rtl/acmp_ctrl.sv
module acmp_ctrl #(
  parameter int LS_DIV    = 2,
  parameter int HS_DIV_LO = 64,
  parameter int HS_DIV_HI = 128,
  parameter int FILT_CNT  = 3,
  parameter int SYNC_CNT  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_tick_i,
  input  logic       ls_tick_i,
  input  logic       cmp_raw_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       clk_sel_i,
  input  logic [1:0] smp_sel_i,
  input  logic [1:0] edge_sel_i,
  input  logic       stop_i,
  output logic       level_o,
  output logic       irq_o,
  output logic       en_clr_o
);
  logic base_tick, filt_on, smp_tick, dec, nxt_lvl;

  acmp_tick_gen #(
    .LS_DIV(LS_DIV), .HS_DIV_LO(HS_DIV_LO), .HS_DIV_HI(HS_DIV_HI)
  ) u_tick (
    .clk_i, .rst_ni, .en_i, .hs_tick_i, .ls_tick_i, .clk_sel_i, .smp_sel_i, .stop_i,
    .base_tick_o(base_tick), .filt_on_o(filt_on), .smp_tick_o(smp_tick)
  );

  acmp_filter #(.FILT_CNT(FILT_CNT), .SYNC_CNT(SYNC_CNT)) u_filt (
    .clk_i, .rst_ni, .en_i, .raw_i(cmp_raw_i), .base_tick_i(base_tick),
    .smp_tick_i(smp_tick), .filt_on_i(filt_on), .level_o,
    .dec_o(dec), .nxt_lvl_o(nxt_lvl)
  );

  acmp_seq u_seq (
    .clk_i, .rst_ni, .en_i, .mode_i, .edge_sel_i, .dec_i(dec),
    .lvl_i(level_o), .nxt_lvl_i(nxt_lvl), .irq_o, .en_clr_o
  );
endmodule

// File: rtl/acmp_ctrl_chk.sv
module acmp_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sup_i,
  input logic irq_o,
  input logic en_clr_o,
  input logic level_o
);
  p_irq_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !sup_i) |=> !irq_o);
  p_clr_with_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_o |-> irq_o);
  p_sup_no_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_i |=> !en_clr_o);
  p_off_no_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
  p_off_level_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(level_o));
endmodule

bind acmp_ctrl acmp_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sup_i(mode_i[1]),
  .irq_o(irq_o), .en_clr_o(en_clr_o), .level_o(level_o)
);

// File: tb/acmp_ctrl_test.sv
module acmp_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hs_tick = 1'b1, ls_tick = 1'b1, raw = 1'b0, en = 1'b0, clk_sel = 1'b1, stop = 1'b0;
  logic [1:0] mode = 2'b01, smp_sel = 2'b00, edge_sel = 2'b00;
  logic level, irq, en_clr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  acmp_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .hs_tick_i(hs_tick), .ls_tick_i(ls_tick),
    .cmp_raw_i(raw), .en_i(en), .mode_i(mode), .clk_sel_i(clk_sel),
    .smp_sel_i(smp_sel), .edge_sel_i(edge_sel), .stop_i(stop),
    .level_o(level), .irq_o(irq), .en_clr_o(en_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [1:0] md, input logic cs, input logic [1:0] ss,
                          input logic [1:0] es, input logic rv);
    @(negedge clk);
    rst_ni = 1'b0; en = 1'b0; stop = 1'b0; hs_tick = 1'b1; ls_tick = 1'b1;
    mode = md; clk_sel = cs; smp_sel = ss; edge_sel = es; raw = rv;
    step(2);
    rst_ni = 1'b1;
    step(4);
  endtask

  // counts edges from now until irq; n = -1 if none within max
  task automatic wait_irq(input int max, output int n, output bit clr);
    n = -1; clr = 1'b0;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin
        n = i; clr = en_clr;
        break;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(level == 1'b0, "R1 level", int'(level), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(en_clr == 1'b0, "R1 en_clr", int'(en_clr), 0);
  endtask

  task automatic t_monitor;
    int n; bit c;
    do_reset(2'b01, 1'b1, 2'b00, 2'b11, 1'b1);
    en = 1'b1;
    wait_irq(10, n, c);
    chk(n == 2, "R2 R6 unfiltered monitor latency", n, 2);
    chk(c == 1'b1, "R11 en_clr with irq", int'(c), 1);
    chk(level == 1'b1, "R6 level", int'(level), 1);
    step(1);
    chk(irq == 1'b0, "R11 irq one cycle", int'(irq), 0);
    chk(en_clr == 1'b0, "R11 en_clr one cycle", int'(en_clr), 0);
    en = 1'b0;
    do_reset(2'b01, 1'b1, 2'b00, 2'b00, 1'b0);
    en = 1'b1;
    wait_irq(10, n, c);
    chk(n == 2 && c, "R2 monitor with no level change", n, 2);
    en = 1'b0;
  endtask

  task automatic t_single_cond;
    int n; bit c;
    do_reset(2'b00, 1'b1, 2'b00, 2'b01, 1'b1);
    en = 1'b1;
    wait_irq(20, n, c);
    chk(n == -1, "R3 R5 rising not matched by falling select", n, -1);
    chk(level == 1'b1, "R3 level rose silently", int'(level), 1);
    raw = 1'b0;
    wait_irq(20, n, c);
    chk(n == 2 && c, "R3 R5 falling match stops", n, 2);
    en = 1'b0;
    step(1);
  endtask

  task automatic t_filt_hs;
    int n; bit c;
    do_reset(2'b01, 1'b1, 2'b10, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(1000, n, c);
    chk(n == 192, "R7 R8 hs period 64 three samples", n, 192);
    en = 1'b0;
    do_reset(2'b01, 1'b1, 2'b11, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(1000, n, c);
    chk(n == 384, "R8 hs period 128", n, 384);
    en = 1'b0;
  endtask

  task automatic t_filt_ls;
    int n; bit c;
    do_reset(2'b01, 1'b0, 2'b01, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(100, n, c);
    chk(n == 6, "R8 ls period 2", n, 6);
    en = 1'b0;
    do_reset(2'b01, 1'b0, 2'b10, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(100, n, c);
    chk(n == 2, "R8 ls select ignores smp bit1", n, 2);
    en = 1'b0;
    do_reset(2'b01, 1'b0, 2'b00, 2'b00, 1'b1);
    ls_tick = 1'b0;
    en = 1'b1;
    wait_irq(40, n, c);
    chk(n == -1, "R8 ls select ignores hs tick", n, -1);
    ls_tick = 1'b1;
    wait_irq(40, n, c);
    chk(n == 2, "R8 ls tick drives sync", n, 2);
    en = 1'b0;
  endtask

  task automatic t_stop;
    int n; bit c;
    do_reset(2'b01, 1'b1, 2'b10, 2'b00, 1'b1);
    stop = 1'b1;
    en = 1'b1;
    wait_irq(300, n, c);
    chk(n == 2, "R9 stop forces unfiltered", n, 2);
    en = 1'b0;
  endtask

  task automatic t_glitch;
    int n; bit c;
    do_reset(2'b10, 1'b1, 2'b10, 2'b10, 1'b0);
    en = 1'b1;
    wait_irq(250, n, c);
    chk(n == -1, "R4 no change no irq", n, -1);
    raw = 1'b1;
    step(100);
    raw = 1'b0;
    wait_irq(500, n, c);
    chk(n == -1, "R7 short pulse rejected", n, -1);
    chk(level == 1'b0, "R7 level unchanged", int'(level), 0);
    raw = 1'b1;
    wait_irq(300, n, c);
    chk(n > 0 && !c, "R4 R7 held level accepted", n, 1);
    chk(level == 1'b1, "R7 level follows", int'(level), 1);
    en = 1'b0;
  endtask

  task automatic t_supervise;
    int n; bit c;
    do_reset(2'b11, 1'b0, 2'b01, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(30, n, c);
    chk(n == 6 && !c, "R4 R5 rise irq no clear", n, 6);
    raw = 1'b0;
    wait_irq(30, n, c);
    chk(n == -1, "R5 fall ignored by rise select", n, -1);
    chk(level == 1'b0, "R4 level fell", int'(level), 0);
    raw = 1'b1;
    wait_irq(30, n, c);
    chk(n > 0 && !c, "R4 second rise irq", n, 1);
    edge_sel = 2'b10;
    raw = 1'b0;
    wait_irq(30, n, c);
    chk(n > 0 && !c, "R5 both select fall", n, 1);
    edge_sel = 2'b11;
    raw = 1'b1;
    wait_irq(30, n, c);
    chk(n == -1, "R5 none select", n, -1);
    chk(level == 1'b1, "R5 level still tracks", int'(level), 1);
    en = 1'b0;
  endtask

  task automatic t_abort;
    int n; bit c;
    do_reset(2'b01, 1'b1, 2'b10, 2'b00, 1'b1);
    en = 1'b1;
    wait_irq(150, n, c);
    chk(n == -1, "R10 not yet complete", n, -1);
    en = 1'b0;
    wait_irq(300, n, c);
    chk(n == -1, "R10 abort no irq", n, -1);
    chk(level == 1'b0, "R10 level held", int'(level), 0);
    en = 1'b1;
    wait_irq(1000, n, c);
    chk(n == 192, "R10 full time after re-enable", n, 192);
    en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(1);
    t_reset();
    rst_ni = 1'b1;
    t_monitor();
    t_single_cond();
    t_filt_hs();
    t_filt_ls();
    t_stop();
    t_glitch();
    t_supervise();
    t_abort();
    finish_run();
  end
endmodule